// File: doc/BRIEF.md
# Luma Contrast, Brightness and Requantization Stage

This block sits in a video pixel path after the colour decoder. It takes 8-bit luma samples together with a multiplexed chroma stream and scales each luma sample by a contrast gain. It then adds a signed brightness offset. The result is held as a 10-bit intermediate value with two fractional bits. That value is reduced back to 8 bits by one of four methods: rounding, truncation, 1-bit error diffusion or 2-bit error diffusion. The 8-bit result is then limited to a selectable floor of 16 or 32 and to a ceiling of 255.

On the chroma side, the two colour-difference samples of each pair can be exchanged, so that a stream ordered blue-first leaves the block red-first. Chroma values themselves are not altered. Control inputs are sampled together with each sample, so a setting change takes effect on an exact sample boundary. Both outputs appear two clock cycles after their input sample.

The error-diffusion residue and the chroma pair phase are cleared by an idle run of `GAP_CYCLES` cycles. Such a run marks a line gap, so every line starts from a clean state.

Top module: `luma_adjust_requant`

## Requirements
- R1: The 6-bit `contrast` code n sets a luma gain of n/32 (0 to 63/32); with brightness code 127 and truncation, the output is floor(n*Y/32), then limited per R8 and R9.
- R2: The 8-bit `brightness` code k adds an offset of k-127 (-127 to +128) to the scaled luma before requantization.
- R3: The intermediate value is q = clip(floor(n*Y/8) + 4*(k-127), 0, 1023), in quarter-LSB units. `quant_mode` 0 rounds: the result is (q+2)/4 (integer division), saturated at 255.
- R4: `quant_mode` 1 truncates: the result is q/4 (integer division).
- R5: `quant_mode` 2 (1-bit diffusion) computes t = q + 2*h, where h is the carried half bit. The result is t/4, saturated at 255. Bit 1 of t becomes the next h.
- R6: `quant_mode` 3 (2-bit diffusion) computes t = q + r, where r is the carried 2-bit residue. The result is t/4, saturated at 255. The value t mod 4 becomes the next r.
- R7: The carried residue is zero after reset and after any sample in mode 0 or 1. It is cleared on the GAP_CYCLES-th consecutive idle cycle. A shorter idle run keeps it.
- R8: A requantized result above 255 saturates at 255. This includes an intermediate value that was clipped at 1023.
- R9: A result below the floor is raised to the floor. `clamp_sel` 0 selects a floor of 16 and 1 selects a floor of 32.
- R10: With `swap_cbcr` set, each chroma pair is exchanged: the first sample of a pair (even phase) leaves with the second sample's value, and the second leaves with the first's. Pairs arrive on consecutive valid cycles.
- R11: `out_valid` follows `in_valid` two cycles later. After reset `out_valid`, `out_luma` and `out_chroma` are 0.
- R12: With `swap_cbcr` clear, chroma passes unchanged. The pair phase starts even after reset and after a line gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_luma | input | 8 | Luma sample |
| in_chroma | input | 8 | Multiplexed chroma sample, blue then red |
| contrast | input | 6 | Gain code n, gain n/32 |
| brightness | input | 8 | Offset code k, offset k-127 |
| quant_mode | input | 2 | 0 round, 1 truncate, 2 one-bit diffusion, 3 two-bit diffusion |
| clamp_sel | input | 1 | Floor select: 0 gives 16, 1 gives 32 |
| swap_cbcr | input | 1 | Exchange chroma pair order |
| out_valid | output | 1 | Output sample qualifier |
| out_luma | output | 8 | Adjusted luma |
| out_chroma | output | 8 | Chroma, pair-swapped when selected |

## Verification
Every result, both luma and chroma, is due exactly two cycles after its sample is presented. The bench drives a sample on one falling edge and checks it on the falling edge two cycles later. Inside each stream task the check for sample i-2 runs at the same falling edge where sample i is driven. The residue is modelled as the bench walks the samples in order. The idle run between streams is set to one cycle short of the line gap or exactly to it, which places the residue clear on a known sample boundary.

// File: rtl/luma_adjust_requant.sv
module luma_adjust_requant #(
  parameter int GAP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_luma,
  input  logic [7:0] in_chroma,
  input  logic [5:0] contrast,
  input  logic [7:0] brightness,
  input  logic [1:0] quant_mode,
  input  logic       clamp_sel,
  input  logic       swap_cbcr,
  output logic       out_valid,
  output logic [7:0] out_luma,
  output logic [7:0] out_chroma
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(GAP_CYCLES);

  logic       v1, k1, s1;
  logic [7:0] y1, c1, b1;
  logic [5:0] n1;
  logic [1:0] m1;

  logic       v2, ph2, s2;
  logic [7:0] yl2, c2, prevc;

  logic          phase;
  logic [1:0]    residue;
  logic [GW-1:0] gcnt;
  logic          gap_clear;

  logic [13:0]        prod;
  logic signed [14:0] sum;
  logic [9:0]         q10;
  logic [1:0]         addv;
  logic [10:0]        t;
  logic [7:0]         yq, lvl, ycl;
  logic [1:0]         res_next;

  assign prod = {8'd0, n1} * {6'd0, y1};
  assign sum  = $signed({4'd0, prod[13:3]}) + $signed({5'd0, b1, 2'b00}) - 15'sd508;

  always_comb begin
    if (sum < 15'sd0)
      q10 = 10'd0;
    else if (sum > 15'sd1023)
      q10 = 10'd1023;
    else
      q10 = sum[9:0];
  end

  always_comb begin
    case (m1)
      2'd0:    addv = 2'd2;
      2'd1:    addv = 2'd0;
      2'd2:    addv = {residue[1], 1'b0};
      default: addv = residue;
    endcase
  end

  assign t   = {1'b0, q10} + {9'd0, addv};
  assign yq  = t[10] ? 8'd255 : t[9:2];
  assign lvl = k1 ? 8'd32 : 8'd16;
  assign ycl = (yq < lvl) ? lvl : yq;

  always_comb begin
    case (m1)
      2'd2:    res_next = {t[1], 1'b0};
      2'd3:    res_next = t[1:0];
      default: res_next = 2'd0;
    endcase
  end

  assign gap_clear = !v1 && (gcnt == GAP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      y1 <= '0;
      c1 <= '0;
      n1 <= '0;
      b1 <= '0;
      m1 <= '0;
      k1 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        y1 <= in_luma;
        c1 <= in_chroma;
        n1 <= contrast;
        b1 <= brightness;
        m1 <= quant_mode;
        k1 <= clamp_sel;
        s1 <= swap_cbcr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt    <= '0;
      residue <= 2'd0;
      phase   <= 1'b0;
    end else if (v1) begin
      gcnt    <= '0;
      residue <= res_next;
      phase   <= ~phase;
    end else begin
      if (gcnt != GAP_FULL)
        gcnt <= gcnt + 1'b1;
      if (gap_clear) begin
        residue <= 2'd0;
        phase   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2    <= 1'b0;
      yl2   <= '0;
      c2    <= '0;
      ph2   <= 1'b0;
      s2    <= 1'b0;
      prevc <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        yl2 <= ycl;
        c2  <= c1;
        ph2 <= phase;
        s2  <= s1;
      end
      if (v2)
        prevc <= c2;
    end
  end

  assign out_valid  = v2;
  assign out_luma   = yl2;
  assign out_chroma = !s2 ? c2 : (ph2 ? prevc : c1);
endmodule

module luma_adjust_requant_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_luma,
  input logic [7:0] in_chroma,
  input logic [5:0] contrast,
  input logic [7:0] brightness,
  input logic [1:0] quant_mode,
  input logic       clamp_sel,
  input logic       swap_cbcr,
  input logic       out_valid,
  input logic [7:0] out_luma,
  input logic [7:0] out_chroma,
  input logic       gap_clear,
  input logic [1:0] residue
);
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  p_floor16_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_luma >= 8'd16);

  p_floor32_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(clamp_sel, 2) && $past(in_valid, 2)) |-> out_luma >= 8'd32);

  p_chroma_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(swap_cbcr, 2)) |-> out_chroma == $past(in_chroma, 2));

  p_unity_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(quant_mode, 2) == 2'd1 && $past(contrast, 2) == 6'd32 &&
     $past(brightness, 2) == 8'd127)
    |-> out_luma == (($past(in_luma, 2) < ($past(clamp_sel, 2) ? 8'd32 : 8'd16)) ?
                     ($past(clamp_sel, 2) ? 8'd32 : 8'd16) : $past(in_luma, 2)));

  p_gap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_clear |=> residue == 2'd0);

  p_nodiff_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, 2) && $past(quant_mode, 2) < 2'd2) |-> residue == 2'd0);
endmodule

bind luma_adjust_requant luma_adjust_requant_sva u_sva (.*);

// File: tb/luma_adjust_requant_tb.sv
module luma_adjust_requant_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_luma = '0, in_chroma = '0, brightness = 8'd127;
  logic [5:0] contrast = 6'd32;
  logic [1:0] quant_mode = 2'd1;
  logic       clamp_sel = 1'b0, swap_cbcr = 1'b0;
  logic       out_valid;
  logic [7:0] out_luma, out_chroma;

  int errors = 0;
  int checks = 0;
  int mres = 0;
  logic [7:0] sy [0:63];
  logic [7:0] sc [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  luma_adjust_requant #(.GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_luma(in_luma),
    .in_chroma(in_chroma), .contrast(contrast), .brightness(brightness),
    .quant_mode(quant_mode), .clamp_sel(clamp_sel), .swap_cbcr(swap_cbcr),
    .out_valid(out_valid), .out_luma(out_luma), .out_chroma(out_chroma));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int y, input int n, input int k,
                               input int mode, input int cl);
    int q, add, tt, r, lv;
    q = (n * y) / 8 + 4 * (k - 127);
    if (q < 0) q = 0;
    if (q > 1023) q = 1023;
    case (mode)
      0: add = 2;
      1: add = 0;
      2: add = mres & 2;
      default: add = mres;
    endcase
    tt = q + add;
    r = (tt > 1023) ? 255 : tt / 4;
    mres = (mode == 3) ? tt % 4 : (mode == 2) ? (tt & 2) : 0;
    lv = cl ? 32 : 16;
    if (r < lv) r = lv;
    return r;
  endfunction

  task automatic fill(input int a, input int b);
    for (int i = 0; i < 64; i++) begin
      sy[i] = 8'((i * a + b) % 256);
      sc[i] = 8'((i * 53 + b + 7) % 256);
    end
  endtask

  task automatic stream(input int len, input int n, input int k, input int mode,
                        input int cl, input int sw, input int idle, input string tag);
    int e;
    for (int i = 0; i < len + 2; i++) begin
      @(negedge clk);
      check({"R11 valid ", tag}, int'(out_valid), (i >= 2) ? 1 : 0);
      if (i >= 2) begin
        int j = i - 2;
        e = model(sy[j], n, k, mode, cl);
        check(tag, int'(out_luma), e);
        if (sw != 0)
          check("R10", int'(out_chroma), (j % 2 == 0) ? int'(sc[j + 1]) : int'(sc[j - 1]));
        else
          check("R12", int'(out_chroma), int'(sc[j]));
      end
      if (i < len) begin
        in_valid = 1'b1;
        in_luma = sy[i];
        in_chroma = sc[i];
        contrast = 6'(n);
        brightness = 8'(k);
        quant_mode = 2'(mode);
        clamp_sel = cl[0];
        swap_cbcr = sw[0];
      end else begin
        in_valid = 1'b0;
        in_luma = 8'hA5;
        in_chroma = 8'h5A;
      end
    end
    repeat (idle) @(negedge clk);
    if (idle + 2 >= GAP) mres = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 reset valid", int'(out_valid), 0);
    check("R11 reset luma", int'(out_luma), 0);
    check("R11 reset chroma", int'(out_chroma), 0);
  endtask

  task automatic t_gain;
    fill(37, 3);
    stream(16, 32, 127, 1, 0, 0, 20, "R1 unity");
    stream(16, 63, 127, 1, 0, 0, 20, "R1 max");
    stream(8, 0, 127, 1, 0, 0, 20, "R1 zero");
    stream(16, 16, 127, 1, 0, 0, 20, "R1 half");
  endtask

  task automatic t_offset;
    fill(29, 90);
    stream(16, 32, 0, 1, 0, 0, 20, "R2 min");
    stream(16, 32, 255, 1, 0, 0, 20, "R2 max");
    stream(16, 40, 100, 1, 0, 0, 20, "R2 mid");
  endtask

  task automatic t_round;
    fill(41, 17);
    stream(20, 45, 127, 0, 0, 0, 20, "R3 round");
    stream(20, 27, 130, 0, 0, 0, 20, "R3 round2");
  endtask

  task automatic t_trunc;
    fill(41, 17);
    stream(20, 45, 127, 1, 0, 0, 20, "R4 trunc");
  endtask

  task automatic t_err1;
    for (int i = 0; i < 64; i++) begin sy[i] = 8'd101; sc[i] = 8'(i); end
    stream(16, 33, 127, 2, 0, 0, 20, "R5 diff1");
    fill(13, 60);
    stream(16, 37, 120, 2, 0, 0, 20, "R5 diff1b");
  endtask

  task automatic t_err2;
    for (int i = 0; i < 64; i++) begin sy[i] = 8'd101; sc[i] = 8'(i); end
    stream(16, 33, 127, 3, 0, 0, 20, "R6 diff2");
    fill(13, 60);
    stream(16, 37, 120, 3, 0, 0, 20, "R6 diff2b");
  endtask

  task automatic t_gap;
    for (int i = 0; i < 64; i++) begin sy[i] = 8'd99; sc[i] = 8'(i); end
    stream(5, 35, 127, 3, 0, 0, GAP - 3, "R7 carry a");
    stream(5, 35, 127, 3, 0, 0, GAP - 2, "R7 carry b");
    stream(5, 35, 127, 3, 0, 0, GAP - 3, "R7 cleared");
    stream(2, 35, 127, 1, 0, 0, GAP - 3, "R7 mode1");
    stream(5, 35, 127, 3, 0, 0, 20, "R7 after mode1");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 64; i++) begin sy[i] = 8'(255 - i); sc[i] = 8'(i); end
    stream(8, 63, 255, 0, 0, 0, 20, "R8 round sat");
    stream(8, 63, 255, 3, 0, 0, 20, "R8 diff sat");
    stream(8, 50, 200, 1, 0, 0, 20, "R8 trunc sat");
  endtask

  task automatic t_clamp;
    fill(7, 0);
    stream(16, 32, 127, 1, 1, 0, 20, "R9 floor32");
    stream(16, 32, 127, 1, 0, 0, 20, "R9 floor16");
    stream(8, 10, 20, 0, 1, 0, 20, "R9 neg32");
  endtask

  task automatic t_swap;
    fill(23, 5);
    stream(16, 32, 127, 1, 0, 1, 20, "R10 luma");
    stream(3, 32, 127, 1, 0, 0, 20, "R12 odd line");
    stream(10, 32, 127, 1, 0, 1, 20, "R10 new line");
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gain();
    t_offset();
    t_round();
    t_trunc();
    t_err1();
    t_err2();
    t_gap();
    t_sat();
    t_clamp();
    t_swap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule